// File: doc/BRIEF.md
# Paired Store Address Generation Unit

This unit takes a 32-bit store-pair instruction for vector/floating-point registers and turns it into a single memory write plus, when the addressing form asks for it, an update of the base register. It reads the element size and the addressing form from the instruction, scales the signed 7-bit immediate by the element size, and chooses the base: the stack pointer when the base field is 31, otherwise the general register value that the caller supplies. The two source register values arrive already read at full vector width. The unit packs the narrow part of each into a write word of twice the element width. The order of the two halves depends on the endianness input.

An instruction is accepted when `issue_valid` and `issue_ready` are both high at a clock edge. In the next cycle the unit either raises a one-cycle fault flag, or it presents the write on a valid/ready memory port and holds it there until the write is accepted. For the forms that update the base register, a one-cycle writeback strobe follows the memory handshake. While a request is in flight, `issue_ready` stays low.

Top module: `pair_store_agu`

## Requirements
- R1: Bits 31:30 select the element size: 00 is 4 bytes, 01 is 8 bytes, 10 is 16 bytes. The byte offset is the sign-extended imm7 field (bits 21:15) multiplied by the element size. In the signed-offset form (bits 24:23 = 10) the write address is base + offset.
- R2: In the post-index form (bits 24:23 = 01) the write address is the unmodified base, and the writeback value is base + offset.
- R3: In the pre-index form (bits 24:23 = 11) both the write address and the writeback value are base + offset.
- R4: The signed-offset form never raises `wb_en`.
- R5: `mem_wdata` carries the two elements in its low 2×size bytes, and every bit above them is zero. When `big_endian` is 0, the element from `rt_data` (the register named by bits 4:0) is in the lower half. When `big_endian` is 1, the element from `rt2_data` (bits 14:10) is in the lower half.
- R6: `mem_bytes` equals twice the element size: 8, 16 or 32.
- R7: A base field (bits 9:5) of 31 selects `base_sp`. Any other value selects `base_gpr`.
- R8: The instruction is undefined, and `undef_flag` pulses for one cycle in the cycle after acceptance with no write and no writeback, in any of these cases: bits 31:30 = 11, bits 29:27 ≠ 101, bit 26 = 0, bit 25 = 1, bit 22 = 1, or bits 24:23 = 00.
- R9: When a defined instruction uses the stack pointer and `base_sp` is not a multiple of 16, `align_fault` pulses for one cycle in the cycle after acceptance, with no write and no writeback. An undefined instruction raises only `undef_flag`.
- R10: `mem_valid` rises in the cycle after acceptance. It stays high, with address, data and byte count unchanged, until the cycle in which `mem_ready` is high.
- R11: For the pre-index and post-index forms, `wb_en` is high for exactly the one cycle after the memory handshake, with `wb_reg` equal to the base field.
- R12: After reset, `issue_ready` is 1 and `mem_valid`, `wb_en`, `undef_flag` and `align_fault` are 0. `issue_ready` is 1 only when no request is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Instruction and operands are present |
| issue_ready | output | 1 | Unit is idle and accepts an instruction |
| instr | input | 32 | Instruction word |
| big_endian | input | 1 | Data endianness for packing |
| base_gpr | input | ADDR_W | Value of the general register named by the base field |
| base_sp | input | ADDR_W | Current stack pointer |
| rt_data | input | ELEM_W | First source register value |
| rt2_data | input | ELEM_W | Second source register value |
| mem_valid | output | 1 | Write request present |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Byte address of the write |
| mem_wdata | output | 2*ELEM_W | Packed write data |
| mem_bytes | output | $clog2(ELEM_W/4)+1 | Number of bytes written |
| wb_en | output | 1 | Base register update strobe |
| wb_reg | output | 5 | Base register index (31 = stack pointer) |
| wb_value | output | ADDR_W | New base register value |
| undef_flag | output | 1 | Undefined instruction pulse |
| align_fault | output | 1 | Stack pointer alignment fault pulse |

## Verification
The bench uses the default parameters: a 64-bit address, 128-bit elements (256-bit write data) and 16-byte stack alignment. With these values all three element sizes can be exercised, including the 16-byte size whose elements fill the full write word. The most negative and most positive immediates can be checked at every scale, including 64-bit wraparound of the base. Stack pointer values with any of their low four bits set trigger the alignment fault. Random stalls on `mem_ready` exercise the hold behaviour and the timing of the writeback.

// File: rtl/pair_store_pkg.sv
`timescale 1ns/1ps
// Shared types for the paired store address unit.
// Assumes the element-size field and the address-form field of the instruction
// map directly onto the enum encodings below.
package pair_store_pkg;

    typedef enum logic [1:0] {
        SZ_W32  = 2'b00,
        SZ_W64  = 2'b01,
        SZ_W128 = 2'b10,
        SZ_BAD  = 2'b11
    } elem_size_e;

    typedef enum logic [1:0] {
        AM_NONE   = 2'b00,
        AM_POST   = 2'b01,
        AM_SIGNED = 2'b10,
        AM_PRE    = 2'b11
    } addr_mode_e;

    typedef struct packed {
        logic       bad;
        elem_size_e size;
        addr_mode_e mode;
        logic [6:0] imm;
        logic [4:0] rn;
    } store_dec_t;

    // log2 of the element size in bytes
    function automatic logic [2:0] size_shift(elem_size_e sz);
        case (sz)
            SZ_W32:  return 3'd2;
            SZ_W64:  return 3'd3;
            SZ_W128: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/pst_decoder.sv
`timescale 1ns/1ps
// Decoder: splits the instruction word into size, address form, immediate and
// base field, and flags every encoding this unit does not accept.
// Assumes the caller has already read the two source registers, so the source
// register index fields are not needed here.
module pst_decoder
    import pair_store_pkg::*;
(
    input  logic [31:0] instr,
    output store_dec_t  dec
);

    logic fixed_ok;
    logic unused_src_fields;

    // the source register numbers only matter to the register read stage
    assign unused_src_fields = ^{instr[14:10], instr[4:0]};

    // fixed opcode bits of the store-pair vector form
    assign fixed_ok = (instr[29:27] == 3'b101) && instr[26] && !instr[25] && !instr[22];

    // field extraction and the undefined check
    always_comb begin
        dec.size = elem_size_e'(instr[31:30]);
        dec.mode = addr_mode_e'(instr[24:23]);
        dec.imm  = instr[21:15];
        dec.rn   = instr[9:5];
        dec.bad  = !fixed_ok || (dec.size == SZ_BAD) || (dec.mode == AM_NONE);
    end

endmodule

// File: rtl/pst_addr_gen.sv
`timescale 1ns/1ps
// Address generator: selects the base, scales the immediate, and forms the
// access address and the writeback value. It also checks stack pointer
// alignment. Assumes SP_ALIGN is a power of two.
module pst_addr_gen
    import pair_store_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int SP_ALIGN = 16
) (
    input  store_dec_t        dec,
    input  logic [ADDR_W-1:0] base_gpr,
    input  logic [ADDR_W-1:0] base_sp,
    output logic [ADDR_W-1:0] access_addr,
    output logic [ADDR_W-1:0] final_addr,
    output logic              sp_fault,
    output logic              writeback
);

    localparam int ALIGN_BITS = $clog2(SP_ALIGN);

    logic              use_sp;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] imm_ext;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] sum;

    // base selection: field value 31 names the stack pointer
    assign use_sp = (dec.rn == 5'd31);
    assign base   = use_sp ? base_sp : base_gpr;

    // sign-extend and scale the immediate by the element size
    assign imm_ext = {{(ADDR_W-7){dec.imm[6]}}, dec.imm};
    assign offset  = imm_ext << size_shift(dec.size);
    assign sum     = base + offset;

    // post-index accesses at the old base, the other forms at the sum
    assign access_addr = (dec.mode == AM_POST) ? base : sum;
    assign final_addr  = sum;
    assign writeback   = (dec.mode == AM_POST) || (dec.mode == AM_PRE);

    // stack pointer must be aligned when it is the base
    assign sp_fault = use_sp && (base_sp[ALIGN_BITS-1:0] != '0);

endmodule

// File: rtl/pst_data_pack.sv
`timescale 1ns/1ps
// Data packer: builds the double-width write word from the two source
// elements for every supported size and picks the one for the decoded size
// and endianness. Assumes ELEM_W is 32 times a power of two.
module pst_data_pack
    import pair_store_pkg::*;
#(
    parameter int ELEM_W = 128
) (
    input  elem_size_e                          size,
    input  logic                                big_endian,
    input  logic [ELEM_W-1:0]                   rt_data,
    input  logic [ELEM_W-1:0]                   rt2_data,
    output logic [2*ELEM_W-1:0]                 wdata,
    output logic [$clog2(2*ELEM_W/8):0]         nbytes
);

    localparam int DATA_W    = 2 * ELEM_W;
    localparam int BYTES_W   = $clog2(DATA_W/8) + 1;
    localparam int NUM_SIZES = $clog2(ELEM_W/32) + 1;

    logic [DATA_W-1:0] le_cand [NUM_SIZES];
    logic [DATA_W-1:0] be_cand [NUM_SIZES];

    // one candidate pair per element width
    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        localparam int W = 32 << g;
        assign le_cand[g] = DATA_W'({rt2_data[W-1:0], rt_data[W-1:0]});
        assign be_cand[g] = DATA_W'({rt_data[W-1:0], rt2_data[W-1:0]});
    end

    // select the candidate for the decoded size
    always_comb begin
        wdata  = '0;
        nbytes = '0;
        for (int i = 0; i < NUM_SIZES; i++) begin
            if (int'(size) == i) begin
                wdata  = big_endian ? be_cand[i] : le_cand[i];
                nbytes = BYTES_W'(8 << i);
            end
        end
    end

endmodule

// File: rtl/pair_store_agu.sv
`timescale 1ns/1ps
// Paired store address generation unit (top).
// Accepts one instruction when idle. In the next cycle it either pulses a
// fault flag or presents the write on the memory port until accepted, then
// pulses the base register update for the writeback forms.
// Assumes the caller keeps operands valid in the cycle issue_valid is high.
module pair_store_agu
    import pair_store_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int ELEM_W   = 128,
    parameter int SP_ALIGN = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          issue_valid,
    output logic                          issue_ready,
    input  logic [31:0]                   instr,
    input  logic                          big_endian,
    input  logic [ADDR_W-1:0]             base_gpr,
    input  logic [ADDR_W-1:0]             base_sp,
    input  logic [ELEM_W-1:0]             rt_data,
    input  logic [ELEM_W-1:0]             rt2_data,
    output logic                          mem_valid,
    input  logic                          mem_ready,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [2*ELEM_W-1:0]           mem_wdata,
    output logic [$clog2(ELEM_W/4):0]     mem_bytes,
    output logic                          wb_en,
    output logic [4:0]                    wb_reg,
    output logic [ADDR_W-1:0]             wb_value,
    output logic                          undef_flag,
    output logic                          align_fault
);

    localparam int DATA_W  = 2 * ELEM_W;
    localparam int BYTES_W = $clog2(DATA_W/8) + 1;

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WB, ST_FLAG} state_e;

    store_dec_t         dec;
    logic [ADDR_W-1:0]  access_addr;
    logic [ADDR_W-1:0]  final_addr;
    logic               sp_fault;
    logic               writeback;
    logic [DATA_W-1:0]  packed_data;
    logic [BYTES_W-1:0] packed_bytes;

    state_e             state_q, state_d;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  data_q;
    logic [BYTES_W-1:0] bytes_q;
    logic [ADDR_W-1:0]  wbval_q;
    logic [4:0]         wbreg_q;
    logic               wbneed_q;
    logic               undef_q;
    logic               fault_q;
    logic               accept;

    pst_decoder u_dec (
        .instr (instr),
        .dec   (dec)
    );

    pst_addr_gen #(.ADDR_W(ADDR_W), .SP_ALIGN(SP_ALIGN)) u_addr (
        .dec         (dec),
        .base_gpr    (base_gpr),
        .base_sp     (base_sp),
        .access_addr (access_addr),
        .final_addr  (final_addr),
        .sp_fault    (sp_fault),
        .writeback   (writeback)
    );

    pst_data_pack #(.ELEM_W(ELEM_W)) u_pack (
        .size       (dec.size),
        .big_endian (big_endian),
        .rt_data    (rt_data),
        .rt2_data   (rt2_data),
        .wdata      (packed_data),
        .nbytes     (packed_bytes)
    );

    assign issue_ready = (state_q == ST_IDLE);
    assign accept      = issue_valid && issue_ready;

    // next-state selection for the request sequence
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (accept) state_d = (dec.bad || sp_fault) ? ST_FLAG : ST_REQ;
            ST_REQ:  if (mem_ready) state_d = wbneed_q ? ST_WB : ST_IDLE;
            ST_WB:   state_d = ST_IDLE;
            ST_FLAG: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state and request payload registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            data_q   <= '0;
            bytes_q  <= '0;
            wbval_q  <= '0;
            wbreg_q  <= '0;
            wbneed_q <= 1'b0;
            undef_q  <= 1'b0;
            fault_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q   <= access_addr;
                data_q   <= packed_data;
                bytes_q  <= packed_bytes;
                wbval_q  <= final_addr;
                wbreg_q  <= dec.rn;
                wbneed_q <= writeback;
                undef_q  <= dec.bad;
                fault_q  <= !dec.bad && sp_fault;
            end
        end
    end

    assign mem_valid   = (state_q == ST_REQ);
    assign mem_addr    = addr_q;
    assign mem_wdata   = data_q;
    assign mem_bytes   = bytes_q;
    assign wb_en       = (state_q == ST_WB);
    assign wb_reg      = wbreg_q;
    assign wb_value    = wbval_q;
    assign undef_flag  = (state_q == ST_FLAG) && undef_q;
    assign align_fault = (state_q == ST_FLAG) && fault_q;

    // a stalled write keeps its payload
    assert_hold_payload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_bytes));

    // a write only starts after an accepted instruction
    assert_start_after_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_valid) |-> $past(issue_valid && issue_ready));

    // the base update follows a completed handshake
    assert_wb_after_handshake_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> $past(mem_valid && mem_ready));

    // flags, write and update never overlap
    assert_exclusive_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_valid, wb_en, undef_flag, align_fault}));

    // idle means nothing is driven on the memory port
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ready |-> !mem_valid && !wb_en);

    // a fault pulse lasts one cycle
    assert_fault_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |=> !align_fault);

endmodule

// File: tb/pair_store_agu_tb_top.sv
`timescale 1ns/1ps
module pair_store_agu_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue_valid = 1'b0;
    logic         issue_ready;
    logic [31:0]  instr = '0;
    logic         big_endian = 1'b0;
    logic [63:0]  base_gpr = '0;
    logic [63:0]  base_sp = '0;
    logic [127:0] rt_data = '0;
    logic [127:0] rt2_data = '0;
    logic         mem_valid;
    logic         mem_ready = 1'b0;
    logic [63:0]  mem_addr;
    logic [255:0] mem_wdata;
    logic [5:0]   mem_bytes;
    logic         wb_en;
    logic [4:0]   wb_reg;
    logic [63:0]  wb_value;
    logic         undef_flag;
    logic         align_fault;

    int errors = 0;
    int checks = 0;
    bit started = 0;
    bit stall_mode = 0;

    always #2.5 clk = ~clk;

    pair_store_agu dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
        .instr(instr), .big_endian(big_endian), .base_gpr(base_gpr), .base_sp(base_sp),
        .rt_data(rt_data), .rt2_data(rt2_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_bytes(mem_bytes), .wb_en(wb_en),
        .wb_reg(wb_reg), .wb_value(wb_value), .undef_flag(undef_flag), .align_fault(align_fault)
    );

    // reference model state: 0 idle, 1 write pending, 2 update, 3 flag
    int           m_phase = 0;
    logic [63:0]  m_addr, m_wbv;
    logic [255:0] m_data;
    int           m_bytes;
    int           m_mode;
    int           m_rn;
    bit           m_wb, m_undef, m_fault;

    function automatic logic [31:0] mk(int opc, int mode, int imm, int rt2, int rn, int rt);
        logic [31:0] w;
        w = {opc[1:0], 3'b101, 1'b1, 1'b0, mode[1:0], 1'b0, imm[6:0], rt2[4:0], rn[4:0], rt[4:0]};
        return w;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // model update on every clock edge, from the requirements
    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            m_phase = 0;
        end else begin
            case (m_phase)
                0: if (issue_valid) begin
                    int opc, mode, w, esz;
                    longint off;
                    logic [63:0] base;
                    logic [255:0] a, b, msk;
                    bit bad;
                    opc  = int'(instr[31:30]);
                    mode = int'(instr[24:23]);
                    bad  = (opc == 3) || (instr[29:27] != 3'b101) || !instr[26] || instr[25]
                           || instr[22] || (mode == 0);
                    m_rn = int'(instr[9:5]);
                    m_mode = mode;
                    base = (m_rn == 31) ? base_sp : base_gpr;
                    esz  = 4 << opc;
                    off  = longint'($signed(instr[21:15])) * esz;
                    m_wbv = base + 64'(off);
                    m_addr = (mode == 1) ? base : m_wbv;
                    m_wb = (mode == 1) || (mode == 3);
                    m_bytes = 2 * esz;
                    w = esz * 8;
                    msk = (256'd1 << w) - 256'd1;
                    a = 256'(rt_data) & msk;
                    b = 256'(rt2_data) & msk;
                    m_data = big_endian ? ((a << w) | b) : ((b << w) | a);
                    m_undef = bad;
                    m_fault = !bad && (m_rn == 31) && (base_sp[3:0] != 4'd0);
                    m_phase = (m_undef || m_fault) ? 3 : 1;
                end
                1: if (mem_ready) m_phase = m_wb ? 2 : 0;
                default: m_phase = 0;
            endcase
        end
    end

    // compare outputs with the model away from the edge
    always @(negedge clk) begin
        if (started) begin
            string areq;
            chk(issue_ready == (m_phase == 0), "R12", "issue_ready", 256'(issue_ready), 256'(m_phase == 0));
            chk(mem_valid == (m_phase == 1), "R10", "mem_valid", 256'(mem_valid), 256'(m_phase == 1));
            chk(wb_en == (m_phase == 2), (m_mode == 2) ? "R4" : "R11", "wb_en", 256'(wb_en), 256'(m_phase == 2));
            chk(undef_flag == (m_phase == 3 && m_undef), "R8", "undef_flag", 256'(undef_flag), 256'(m_phase == 3 && m_undef));
            chk(align_fault == (m_phase == 3 && m_fault), "R9", "align_fault", 256'(align_fault), 256'(m_phase == 3 && m_fault));
            if (m_phase == 1) begin
                if (m_rn == 31) areq = "R7";
                else if (m_mode == 1) areq = "R2";
                else if (m_mode == 3) areq = "R3";
                else areq = "R1";
                chk(mem_addr == m_addr, areq, "mem_addr", 256'(mem_addr), 256'(m_addr));
                chk(mem_wdata == m_data, "R5", "mem_wdata", mem_wdata, m_data);
                chk(int'(mem_bytes) == m_bytes, "R6", "mem_bytes", 256'(mem_bytes), 256'(m_bytes));
            end
            if (m_phase == 2) begin
                chk(wb_value == m_wbv, (m_mode == 1) ? "R2" : "R3", "wb_value", 256'(wb_value), 256'(m_wbv));
                chk(int'(wb_reg) == m_rn, "R11", "wb_reg", 256'(wb_reg), 256'(m_rn));
            end
        end
    end

    // memory side acceptance pattern
    always @(negedge clk) begin
        mem_ready <= stall_mode ? ($urandom_range(0, 3) == 0) : 1'b1;
    end

    task automatic send(logic [31:0] w, bit be, logic [63:0] g, logic [63:0] sp,
                        logic [127:0] d1, logic [127:0] d2);
        @(negedge clk);
        while (!issue_ready) @(negedge clk);
        instr = w; big_endian = be; base_gpr = g; base_sp = sp;
        rt_data = d1; rt2_data = d2; issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [127:0] pa, pb;
        pa = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
        pb = 128'hfffefdfc_fbfaf9f8_f7f6f5f4_f3f2f1f0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 R6 signed offset at each size, both endian orders (R5)
        for (int s = 0; s < 3; s++) begin
            send(mk(s, 2, 7'h05, 2, 3, 1), 0, 64'h1000, 64'h0, pa, pb);
            send(mk(s, 2, 7'h05, 2, 3, 1), 1, 64'h1000, 64'h0, pa, pb);
        end
        // R2 R3 extreme immediates, including wraparound below zero
        for (int s = 0; s < 3; s++) begin
            send(mk(s, 1, 7'h40, 4, 7, 5), 0, 64'h10, 64'h0, pa, pb);
            send(mk(s, 3, 7'h3f, 4, 7, 5), 0, 64'h2000, 64'h0, pa, pb);
            send(mk(s, 3, 7'h40, 4, 7, 5), 1, 64'h0, 64'h0, pa, pb);
        end
        // R7 stack pointer base, aligned
        send(mk(1, 3, 7'h7e, 0, 31, 1), 0, 64'hdead, 64'h8000, pa, pb);
        send(mk(2, 1, 7'h02, 0, 31, 1), 0, 64'hdead, 64'h8000, pa, pb);
        // R9 misaligned stack pointer
        send(mk(0, 2, 7'h01, 0, 31, 1), 0, 64'h0, 64'h8004, pa, pb);
        send(mk(2, 3, 7'h01, 0, 31, 1), 0, 64'h0, 64'h8008, pa, pb);
        // R8 undefined encodings, one taking priority over misalignment
        send(mk(3, 2, 7'h01, 0, 3, 1), 0, 64'h100, 64'h0, pa, pb);
        send(mk(0, 0, 7'h01, 0, 3, 1), 0, 64'h100, 64'h0, pa, pb);
        send(mk(1, 2, 7'h01, 0, 3, 1) | 32'h0040_0000, 0, 64'h100, 64'h0, pa, pb);
        send(mk(1, 2, 7'h01, 0, 3, 1) | 32'h0200_0000, 0, 64'h100, 64'h0, pa, pb);
        send(mk(1, 2, 7'h01, 0, 3, 1) & ~32'h0400_0000, 0, 64'h100, 64'h0, pa, pb);
        send(mk(1, 2, 7'h01, 0, 3, 1) ^ 32'h1000_0000, 0, 64'h100, 64'h0, pa, pb);
        send(mk(3, 1, 7'h01, 0, 31, 1), 0, 64'h0, 64'h8001, pa, pb);
        // R10 R11 random traffic under backpressure
        stall_mode = 1;
        for (int n = 0; n < 200; n++) begin
            logic [31:0] w;
            int rn;
            logic [63:0] sp;
            rn = ($urandom_range(0, 3) == 0) ? 31 : int'($urandom_range(0, 30));
            w = mk(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(0, 127)),
                   int'($urandom_range(0, 31)), rn, int'($urandom_range(0, 31)));
            if ($urandom_range(0, 9) == 0) w = w ^ (32'd1 << $urandom_range(22, 29));
            sp = {$urandom, $urandom};
            if ($urandom_range(0, 2) != 0) sp[3:0] = 4'd0;
            send(w, 1'($urandom_range(0, 1)), {$urandom, $urandom}, sp,
                 {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom});
        end
        stall_mode = 0;
        repeat (10) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule